// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a miss in a translation cache by reading one page table entry from memory. When a miss arrives it records the virtual page number and the kind of access, and forms the entry address from the table base register. It then issues a single memory read and waits for the reply, which may take any number of cycles. The returned 32-bit entry is decoded and checked.

A cleared valid bit ends the walk with a page fault. A valid entry whose rights do not cover the access ends with a protection fault. Otherwise the translation is handed back for refill. Only one miss is handled at a time. The table base may be rewritten by a context switch while a walk is running, and the running walk keeps the base it captured.

The refilled physical page number is meant to be joined with the untouched page offset by the requester. A fault never produces a refill.

Top module: `pt_walker`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `busy`, `memReq`, `refillValid`, `pageFault` and `protFault` are all 0.
- R2: A miss accepted while idle raises `memReq` for exactly one cycle, in the cycle after acceptance. In that cycle `memAddr` equals the base plus four times the virtual page number, because each entry is 32 bits.
- R3: The walk uses the `ptBase` value sampled when the miss is accepted. Changing `ptBase` afterwards does not alter `memAddr`.
- R4: An entry with bit 31 (valid) at 0 gives a one-cycle `pageFault` pulse with `refillValid` and `protFault` both 0, whatever the rights bits hold.
- R5: The rights live in bit 30 (read), bit 29 (write) and bit 28 (execute). `missAcc` 0 (load) needs read, 1 (store) needs write, and 2 (fetch) needs execute. Code 3 is reserved and never allowed. A valid entry lacking the needed right gives a one-cycle `protFault` pulse with `refillValid` and `pageFault` both 0.
- R6: A valid, permitted entry gives a one-cycle `refillValid` pulse. With it, `refillPpn` equals the entry's low PPN_W bits, `refillTag` equals the requested virtual page number, and `refillRights` equals entry bits 30:28.
- R7: The reply may arrive after any delay. The outcome is 0 on the cycle after the reply is sampled and appears on the cycle after that, for one cycle only.
- R8: `busy` is 1 from the cycle after acceptance until the outcome cycle ends. A miss presented while busy is dropped and starts no read.
- R9: Each walk ends in exactly one of refill, page fault and protection fault.
- R10: `memRspValid` is ignored unless a read is outstanding. A reply offered while idle, or in the issue cycle, does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Miss request present |
| missVpn | input | VPN_W | Virtual page number of the miss |
| missAcc | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 reserved |
| ptBase | input | ADDR_W | Page table base address |
| busy | output | 1 | A walk is in progress |
| memReq | output | 1 | One-cycle memory read request |
| memAddr | output | ADDR_W | Address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Returned table entry |
| refillValid | output | 1 | Translation ready for refill |
| refillTag | output | VPN_W | Virtual page number of the refill |
| refillPpn | output | PPN_W | Physical page number of the refill |
| refillRights | output | 3 | Read/write/execute rights of the refill |
| pageFault | output | 1 | Entry was not valid |
| protFault | output | 1 | Access not permitted by the entry |

## Verification
A controller stuck in or skipping a state shows up as a missing or repeated `memReq` pulse. It can also appear as an outcome arriving one cycle early or late relative to the reply. Both are visible within two cycles of the reply edge. A wrongly captured page number or base shows at once in `memAddr` in the issue cycle, and again in `refillTag` at the outcome. A faulty rights decode turns a refill into a protection fault, or the reverse, for specific access and rights pairs. A sweep over every pairing of access kind, rights value and valid bit exposes it on the first affected walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int ENTRY_W  = 32;
  localparam int VALID_IX = 31;
  localparam int RD_IX    = 30;
  localparam int WR_IX    = 29;
  localparam int EX_IX    = 28;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ISSUE = 3'd1,
    ST_WAIT  = 3'd2,
    ST_CHECK = 3'd3,
    ST_DONE  = 3'd4
  } walkState_t;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_t;

  typedef struct packed {
    logic capReq;   // take miss fields and form entry address
    logic capRsp;   // take returned entry word
    logic latchRes; // register outcome
    logic clearRes; // drop outcome pulses
  } walkStrobes_t;

endpackage

// File: rtl/ptw_perm.sv
module ptw_perm
  import ptw_pkg::*;
(
  input  logic [1:0] accKind,
  input  logic [2:0] rights,   // {read, write, execute}
  output logic       allowed
);
  always_comb begin
    unique case (accKind)
      ACC_LOAD:  allowed = rights[2];
      ACC_STORE: allowed = rights[1];
      ACC_FETCH: allowed = rights[0];
      default:   allowed = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         missValid,
  input  logic         memRspValid,
  output walkStrobes_t stb,
  output logic         busy,
  output logic         memReq
);
  walkState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    stb    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (missValid) begin
          stb.capReq = 1'b1;
          stateD     = ST_ISSUE;
        end
      end
      ST_ISSUE: stateD = ST_WAIT;
      ST_WAIT: begin
        if (memRspValid) begin
          stb.capRsp = 1'b1;
          stateD     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        stb.latchRes = 1'b1;
        stateD       = ST_DONE;
      end
      ST_DONE: begin
        stb.clearRes = 1'b1;
        stateD       = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy   = (stateQ != ST_IDLE);
  assign memReq = (stateQ == ST_ISSUE);
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int VPN_W  = 8,
  parameter int PPN_W  = 20,
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobes_t       stb,
  input  logic [VPN_W-1:0]   missVpn,
  input  logic [1:0]         missAcc,
  input  logic [ADDR_W-1:0]  ptBase,
  input  logic [ENTRY_W-1:0] memRspData,
  output logic [ADDR_W-1:0]  memAddr,
  output logic               refillValid,
  output logic [VPN_W-1:0]   refillTag,
  output logic [PPN_W-1:0]   refillPpn,
  output logic [2:0]         refillRights,
  output logic               pageFault,
  output logic               protFault
);
  localparam int PAD_W = ADDR_W - VPN_W - 2;

  logic [VPN_W-1:0]   vpnQ;
  logic [1:0]         accQ;
  logic [ADDR_W-1:0]  addrQ;
  logic [ENTRY_W-1:0] pteQ;
  logic               okPerm;
  logic               pteValid;
  logic [2:0]         pteRights;
  logic [ADDR_W-1:0]  offsetW;

  assign offsetW   = {{PAD_W{1'b0}}, missVpn, 2'b00};
  assign pteValid  = pteQ[VALID_IX];
  assign pteRights = {pteQ[RD_IX], pteQ[WR_IX], pteQ[EX_IX]};

  ptw_perm u_perm (
    .accKind (accQ),
    .rights  (pteRights),
    .allowed (okPerm)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ  <= '0;
      accQ  <= '0;
      addrQ <= '0;
    end else if (stb.capReq) begin
      vpnQ  <= missVpn;
      accQ  <= missAcc;
      addrQ <= ptBase + offsetW;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           pteQ <= '0;
    else if (stb.capRsp) pteQ <= memRspData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refillValid  <= 1'b0;
      pageFault    <= 1'b0;
      protFault    <= 1'b0;
      refillTag    <= '0;
      refillPpn    <= '0;
      refillRights <= '0;
    end else if (stb.latchRes) begin
      refillValid  <= pteValid & okPerm;
      pageFault    <= ~pteValid;
      protFault    <= pteValid & ~okPerm;
      refillTag    <= vpnQ;
      refillPpn    <= pteQ[PPN_W-1:0];
      refillRights <= pteRights;
    end else if (stb.clearRes) begin
      refillValid <= 1'b0;
      pageFault   <= 1'b0;
      protFault   <= 1'b0;
    end
  end

  assign memAddr = addrQ;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VPN_W  = 8,
  parameter int PPN_W  = 20,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              missValid,
  input  logic [VPN_W-1:0]  missVpn,
  input  logic [1:0]        missAcc,
  input  logic [ADDR_W-1:0] ptBase,
  output logic              busy,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  output logic              refillValid,
  output logic [VPN_W-1:0]  refillTag,
  output logic [PPN_W-1:0]  refillPpn,
  output logic [2:0]        refillRights,
  output logic              pageFault,
  output logic              protFault
);
  walkStrobes_t stb;

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .missValid   (missValid),
    .memRspValid (memRspValid),
    .stb         (stb),
    .busy        (busy),
    .memReq      (memReq)
  );

  ptw_datapath #(
    .VPN_W  (VPN_W),
    .PPN_W  (PPN_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .missVpn      (missVpn),
    .missAcc      (missAcc),
    .ptBase       (ptBase),
    .memRspData   (memRspData),
    .memAddr      (memAddr),
    .refillValid  (refillValid),
    .refillTag    (refillTag),
    .refillPpn    (refillPpn),
    .refillRights (refillRights),
    .pageFault    (pageFault),
    .protFault    (protFault)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRspValid,
  input logic              refillValid,
  input logic [2:0]        refillRights,
  input logic              pageFault,
  input logic              protFault
);
  logic anyRes;
  assign anyRes = refillValid | pageFault | protFault;

  // R2
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  // R9
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({refillValid, pageFault, protFault}));

  // R7
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyRes |=> !anyRes);

  // R8
  req_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || anyRes) |-> busy);

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memAddr));

  // R6
  refill_rights_chk: assert property (@(posedge clk) disable iff (!rstN)
    refillValid |-> (refillRights != 3'b000));

  // R10
  res_after_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyRes |-> $past(memRspValid, 2));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .busy         (busy),
  .memReq       (memReq),
  .memAddr      (memAddr),
  .memRspValid  (memRspValid),
  .refillValid  (refillValid),
  .refillRights (refillRights),
  .pageFault    (pageFault),
  .protFault    (protFault)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  localparam int VPN_W  = 8;
  localparam int PPN_W  = 20;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              missValid = 1'b0;
  logic [VPN_W-1:0]  missVpn = '0;
  logic [1:0]        missAcc = '0;
  logic [ADDR_W-1:0] ptBase = '0;
  logic              busy, memReq;
  logic [ADDR_W-1:0] memAddr;
  logic              memRspValid = 1'b0;
  logic [31:0]       memRspData = '0;
  logic              refillValid, pageFault, protFault;
  logic [VPN_W-1:0]  refillTag;
  logic [PPN_W-1:0]  refillPpn;
  logic [2:0]        refillRights;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;
  bit doneRun = 1'b0;

  always #5 clk = ~clk;

  pt_walker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ADDR_W(ADDR_W)) u_pt_walker (
    .clk(clk), .rstN(rstN), .missValid(missValid), .missVpn(missVpn),
    .missAcc(missAcc), .ptBase(ptBase), .busy(busy), .memReq(memReq),
    .memAddr(memAddr), .memRspValid(memRspValid), .memRspData(memRspData),
    .refillValid(refillValid), .refillTag(refillTag), .refillPpn(refillPpn),
    .refillRights(refillRights), .pageFault(pageFault), .protFault(protFault)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !doneRun) begin
      nFails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finishRun();
    end
  end

  // opt bits: 0 change base after accept, 1 stray miss while busy, 2 stray rsp in issue cycle
  task automatic walk(input logic [VPN_W-1:0] vpn, input logic [1:0] acc,
                      input logic [31:0] pte, input logic [ADDR_W-1:0] base,
                      input int lat, input int opt);
    logic v, ok;
    logic [2:0] rt;
    v  = pte[31];
    rt = pte[30:28];
    case (acc)
      2'd0: ok = rt[2];
      2'd1: ok = rt[1];
      2'd2: ok = rt[0];
      default: ok = 1'b0;
    endcase
    @(negedge clk);
    missValid = 1'b1; missVpn = vpn; missAcc = acc; ptBase = base;
    @(negedge clk); // issue cycle
    missValid = 1'b0;
    if (opt[0]) ptBase = ~base;             // R3
    if (opt[1]) begin missValid = 1'b1; missVpn = ~vpn; end // R8 stray
    if (opt[2]) begin memRspValid = 1'b1; memRspData = ~pte; end // R10 stray
    check("R2 memReq", memReq, 1);
    check("R2 R3 memAddr", memAddr, base + ADDR_W'(4 * int'(vpn)));
    check("R8 busy", busy, 1);
    @(negedge clk); // wait state
    memRspValid = 1'b0;
    check("R2 memReq one cycle", memReq, 0);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check("R8 no second request", memReq, 0);
    end
    memRspValid = 1'b1; memRspData = pte;
    @(negedge clk); // check state
    memRspValid = 1'b0; memRspData = ~pte;
    check("R7 outcome not early", {refillValid, pageFault, protFault}, 0);
    @(negedge clk); // done state
    missValid = 1'b0;
    check("R4 pageFault", pageFault, !v);
    check("R5 protFault", protFault, v & !ok);
    check("R6 R9 refillValid", refillValid, v & ok);
    if (v & ok) begin
      check("R6 refillPpn", refillPpn, pte[PPN_W-1:0]);
      check("R6 refillTag", refillTag, vpn);
      check("R6 refillRights", refillRights, rt);
    end
    @(negedge clk); // idle again
    check("R7 outcome one cycle", {refillValid, pageFault, protFault}, 0);
    check("R8 idle after walk", {busy, memReq}, 0);
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {busy, memReq, refillValid, pageFault, protFault}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {busy, memReq, refillValid, pageFault, protFault}, 0);

    // R10 reply while idle is ignored
    memRspValid = 1'b1; memRspData = 32'h0;
    @(negedge clk);
    memRspValid = 1'b0;
    check("R10 idle reply ignored", {busy, refillValid, pageFault, protFault}, 0);

    // R4 R5 R6 R9: every access kind, rights value and valid bit
    for (int a = 0; a < 4; a++)
      for (int r = 0; r < 8; r++)
        for (int vb = 0; vb < 2; vb++) begin
          logic [VPN_W-1:0] vp;
          logic [31:0] pte;
          vp  = VPN_W'(a * 61 + r * 7 + vb * 3);
          pte = {vb[0], r[2:0], 8'h00, 20'((a * 40503 + r * 977 + 13) & 32'hFFFFF)};
          walk(vp, a[1:0], pte, 32'h8000_0000 + 32'(a * 4096), (a + r) % 5, (r + vb) % 8);
        end

    // R2 R3 R7: every page number, varied latency and base
    for (int p = 0; p < 256; p++) begin
      logic [31:0] pte;
      pte = {1'b1, 3'b111, 8'h00, 20'((p * 2731 + 5) & 32'hFFFFF)};
      walk(VPN_W'(p), 2'(p % 3), pte, 32'h0010_0000 + 32'((p % 7) * 32'h1_0000), p % 9, p % 8);
    end

    // R7 long latency
    walk(8'hFF, 2'd2, {1'b1, 3'b001, 28'h00ABCDE}, 32'hFFFF_F000, 40, 3);

    doneRun = 1'b1;
    finishRun();
  end
endmodule